// File: doc/BRIEF.md
# MDIO PHY Status Auto-Poller

This block watches an external Ethernet PHY without software involvement. While enabled, it generates the management clock (MDC) from the system clock. It shifts out clause-22 read frames on the management data line, reads the PHY's status register (register 1), and keeps the last value it read on an output port. When a newly read word differs from the stored one, and interrupts are enabled, it emits a one-cycle interrupt pulse. The first read after enabling only primes the stored value.

A small configuration register inside the block holds the controls. These are an enable bit, an interrupt-enable bit, a 3-bit dwell code that sets the idle gap between reads in MDC cycles, a 2-bit code that selects the MDC rate, and the 5-bit PHY address. A three-bit write mask updates these fields in groups.

A hard reset returns the configuration to its defaults. A soft reset only aborts the frame in flight and re-primes the change detector. With a 20 MHz system clock, the rate codes give 2.5, 10 and 5 MHz.

Top module: `mdio_status_poller`

## Requirements
- R1: No read frame starts while the enable bit is 0 and `mdio_oe` stays low between frames. Clearing the enable lets a frame already in progress finish, and then no further frame starts.
- R2: Each frame spans 64 MDC cycles, and the block changes `mdio_o` only when MDC falls. The frame is built as follows:
  - 32 ones;
  - start bits 0,1;
  - opcode 1,0;
  - the PHY address, MSB first;
  - register address 00001, MSB first;
  - two turnaround cycles and 16 data cycles with `mdio_oe` low.

  The block samples the data MSB first when MDC rises.
- R3: The MDC period is 8 system clocks for rate code 00, 2 for 01, 4 for 10, and 8 for the reserved code 11.
- R4: Dwell code N selects a gap of G idle MDC cycles between the last data bit and the next preamble bit. Counted in MDC rising edges, the next preamble bit is sampled G+1 rising edges after the last data bit. G is 0 for code 000, 128 for 001, 256 for 010, 512 for 011, 1024 for 100 and 2048 for 101. The reserved codes 110 and 111 behave as 000.
- R5: The first read after the enable bit goes from 0 to 1 loads `status` without an interrupt.
- R6: When a later read differs from `status` and interrupts are enabled, `irq` is high for exactly one cycle, and `status` takes the new value in that same cycle. A read equal to `status` raises no interrupt.
- R7: With the interrupt-enable bit at 0, changed reads still update `status` but `irq` stays low.
- R8: A hard reset clears `status`, `irq`, `mdc` and `mdio_oe`. It also sets the configuration to: enable 0, interrupt enable 0, dwell code 100, rate code 00, PHY address 0.
- R9: A soft reset aborts the current frame, releases `mdio_oe`, and makes the next read a priming read (no interrupt). It leaves the configuration and `status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Hard reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| cfg_we | input | 3 | Write mask: bit0 enables, bit1 dwell code, bit2 rate code and PHY address |
| cfg_en | input | 1 | Poll enable value |
| cfg_irq_en | input | 1 | Interrupt enable value |
| cfg_dwell | input | 3 | Dwell code value |
| cfg_rate | input | 2 | MDC rate code value |
| cfg_phy | input | 5 | PHY address value |
| mdio_i | input | 1 | Management data from the PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven to the PHY |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| status | output | 16 | Last status word read |
| irq | output | 1 | One-cycle pulse on a status change |

## Verification
The embedded assertions check several rules on every cycle:
- `mdio_oe` stays low outside the shifting state and through turnaround and data;
- `mdio_o` moves only on a falling MDC edge;
- MDC rises only after a rise tick;
- `irq` is a lone pulse that coincides with a changed `status` and follows an armed, interrupt-enabled detector;
- the configuration holds without a write.

Only the bench scenarios can show the rest, because each needs a model PHY and counting across many frames:
- the exact frame fields;
- MDC periods per rate code;
- the measured gap for each dwell code;
- the priming read after enable or soft reset;
- the configuration defaults after a hard reset.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DWELL = 2'd2
  } eng_state_t;

  typedef struct packed {
    logic       en;
    logic       irq_en;
    logic [2:0] dwell;
    logic [1:0] rate;
    logic [4:0] phy;
  } poll_cfg_t;

  localparam int unsigned   DATA_W   = 16;
  localparam logic [5:0]    IDX_PRE  = 6'd32;
  localparam logic [5:0]    IDX_PHY  = 6'd40;  // last PHY address bit
  localparam logic [5:0]    IDX_REG  = 6'd45;  // last register address bit
  localparam logic [5:0]    IDX_TA   = 6'd46;
  localparam logic [5:0]    IDX_DATA = 6'd48;
  localparam logic [5:0]    IDX_LAST = 6'd63;

  // Value driven on the data line for frame position i.
  function automatic logic frame_bit(input logic [5:0] i,
                                     input logic [4:0] pa,
                                     input logic [4:0] ra);
    logic [5:0] k;
    logic       b;
    k = 6'd0;
    b = 1'b1;
    if (i < IDX_PRE) begin
      b = 1'b1;
    end else if (i == 6'd32 || i == 6'd35) begin
      b = 1'b0;
    end else if (i == 6'd33 || i == 6'd34) begin
      b = 1'b1;
    end else if (i <= IDX_PHY) begin
      k = IDX_PHY - i;
      b = pa[k[2:0]];
    end else if (i <= IDX_REG) begin
      k = IDX_REG - i;
      b = ra[k[2:0]];
    end
    return b;
  endfunction

endpackage

// File: rtl/mdp_cfg.sv
module mdp_cfg
  import mdp_pkg::*;
#(
  parameter logic [2:0] RST_DWELL = 3'b100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] we,
  input  logic       en,
  input  logic       irq_en,
  input  logic [2:0] dwell,
  input  logic [1:0] rate,
  input  logic [4:0] phy,
  output poll_cfg_t  cfg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.en     <= 1'b0;
      cfg.irq_en <= 1'b0;
      cfg.dwell  <= RST_DWELL;
      cfg.rate   <= 2'b00;
      cfg.phy    <= 5'd0;
    end else begin
      if (we[0]) begin
        cfg.en     <= en;
        cfg.irq_en <= irq_en;
      end
      if (we[1]) cfg.dwell <= dwell;
      if (we[2]) begin
        cfg.rate <= rate;
        cfg.phy  <= phy;
      end
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (we == 3'b000) |=> $stable(cfg)); // R9

endmodule

// File: rtl/mdp_mdc_gen.sv
module mdp_mdc_gen #(
  parameter int unsigned DIV_R0 = 8,
  parameter int unsigned DIV_R1 = 2,
  parameter int unsigned DIV_R2 = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       soft_rst,
  input  logic [1:0] rate,
  output logic       mdc,
  output logic       rise_tick,
  output logic       fall_tick
);

  localparam int unsigned H0   = DIV_R0 / 2;
  localparam int unsigned H1   = DIV_R1 / 2;
  localparam int unsigned H2   = DIV_R2 / 2;
  localparam int unsigned HMAX = (H0 > H1) ? ((H0 > H2) ? H0 : H2) : ((H1 > H2) ? H1 : H2);
  localparam int unsigned CW   = $clog2(HMAX + 1) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          wrap;

  always_comb begin
    case (rate)
      2'b01:   lim = CW'(H1 - 1);
      2'b10:   lim = CW'(H2 - 1);
      default: lim = CW'(H0 - 1);  // 00 and reserved 11
    endcase
  end

  assign wrap      = (cnt >= lim);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_MDC_RISE_TICK: assert property (@(posedge clk) disable iff (rst || soft_rst)
    $rose(mdc) |-> $past(rise_tick)); // R3

endmodule

// File: rtl/mdp_frame_engine.sv
module mdp_frame_engine
  import mdp_pkg::*;
#(
  parameter int unsigned DWELL_BASE = 128,
  parameter logic [4:0]  STAT_REG   = 5'd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              en,
  input  logic [2:0]        dwell,
  input  logic [4:0]        phy,
  input  logic              mdc,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned DMAX = DWELL_BASE * 16;
  localparam int unsigned DCW  = $clog2(DMAX + 1);

  eng_state_t       state;
  logic [5:0]       idx;
  logic [5:0]       idx_nx;
  logic [DCW-1:0]   dcnt;
  logic [DCW-1:0]   dwell_n;

  // Idle MDC cycles between frames; reserved codes run back to back.
  always_comb begin
    case (dwell)
      3'd1:    dwell_n = DCW'(DWELL_BASE);
      3'd2:    dwell_n = DCW'(DWELL_BASE * 2);
      3'd3:    dwell_n = DCW'(DWELL_BASE * 4);
      3'd4:    dwell_n = DCW'(DWELL_BASE * 8);
      3'd5:    dwell_n = DCW'(DWELL_BASE * 16);
      default: dwell_n = '0;
    endcase
  end

  assign idx_nx = idx + 6'd1;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      state   <= ST_IDLE;
      idx     <= 6'd0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
      dcnt    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          mdio_oe <= 1'b0;
          if (en && fall_tick) begin
            state   <= ST_SHIFT;
            idx     <= 6'd0;
            mdio_o  <= frame_bit(6'd0, phy, STAT_REG);
            mdio_oe <= 1'b1;
          end
        end
        ST_SHIFT: begin
          if (fall_tick && idx != IDX_LAST) begin
            idx     <= idx_nx;
            mdio_o  <= frame_bit(idx_nx, phy, STAT_REG);
            mdio_oe <= (idx_nx < IDX_TA);
          end
          if (rise_tick && idx >= IDX_DATA) begin
            rd_data <= {rd_data[DATA_W-2:0], mdio_i};
            if (idx == IDX_LAST) begin
              done  <= 1'b1;
              dcnt  <= dwell_n;
              state <= (dwell_n == '0) ? ST_IDLE : ST_DWELL;
            end
          end
        end
        ST_DWELL: begin
          if (!en) begin
            state <= ST_IDLE;
          end else if (rise_tick) begin
            if (dcnt <= DCW'(1)) state <= ST_IDLE;
            else                 dcnt  <= dcnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (state != ST_SHIFT) |-> !mdio_oe); // R1

  AST_TA_RELEASED: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (state == ST_SHIFT && idx >= IDX_TA) |-> !mdio_oe); // R2

  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (!$past(soft_rst) && $changed(mdio_o)) |-> $fell(mdc)); // R2

endmodule

// File: rtl/mdp_change_det.sv
module mdp_change_det
  import mdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              en,
  input  logic              irq_en,
  input  logic              done,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] status,
  output logic              irq
);

  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      armed  <= 1'b0;
      irq    <= 1'b0;
    end else if (soft_rst) begin
      armed <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (done) begin
        status <= rd_data;
        irq    <= armed && irq_en && (rd_data != status);
        armed  <= 1'b1;
      end
      if (!en) armed <= 1'b0;
    end
  end

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst || soft_rst)
    irq |=> !irq); // R6

  AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (rst || soft_rst)
    irq |-> (status != $past(status))); // R6

  AST_IRQ_ARMED: assert property (@(posedge clk) disable iff (rst || soft_rst)
    irq |-> $past(armed && irq_en)); // R5

endmodule

// File: rtl/mdio_status_poller.sv
module mdio_status_poller
  import mdp_pkg::*;
#(
  parameter int unsigned DIV_R0     = 8,
  parameter int unsigned DIV_R1     = 2,
  parameter int unsigned DIV_R2     = 4,
  parameter int unsigned DWELL_BASE = 128,
  parameter logic [2:0]  RST_DWELL  = 3'b100,
  parameter logic [4:0]  STAT_REG   = 5'd1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        soft_rst,
  input  logic [2:0]  cfg_we,
  input  logic        cfg_en,
  input  logic        cfg_irq_en,
  input  logic [2:0]  cfg_dwell,
  input  logic [1:0]  cfg_rate,
  input  logic [4:0]  cfg_phy,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] status,
  output logic        irq
);

  poll_cfg_t         cfg;
  logic              rise_tick;
  logic              fall_tick;
  logic              done;
  logic [DATA_W-1:0] rd_data;

  mdp_cfg #(.RST_DWELL(RST_DWELL)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .en     (cfg_en),
    .irq_en (cfg_irq_en),
    .dwell  (cfg_dwell),
    .rate   (cfg_rate),
    .phy    (cfg_phy),
    .cfg    (cfg)
  );

  mdp_mdc_gen #(.DIV_R0(DIV_R0), .DIV_R1(DIV_R1), .DIV_R2(DIV_R2)) u_mdc (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .rate      (cfg.rate),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdp_frame_engine #(.DWELL_BASE(DWELL_BASE), .STAT_REG(STAT_REG)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .en        (cfg.en),
    .dwell     (cfg.dwell),
    .phy       (cfg.phy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (done),
    .rd_data   (rd_data)
  );

  mdp_change_det u_det (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .en       (cfg.en),
    .irq_en   (cfg.irq_en),
    .done     (done),
    .rd_data  (rd_data),
    .status   (status),
    .irq      (irq)
  );

endmodule

// File: tb/test_mdio_status_poller.sv
`timescale 1ns/1ps
module test_mdio_status_poller;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic [2:0]  cfg_we = 3'b000;
  logic        cfg_en = 1'b0;
  logic        cfg_irq_en = 1'b0;
  logic [2:0]  cfg_dwell = 3'b000;
  logic [1:0]  cfg_rate = 2'b00;
  logic [4:0]  cfg_phy = 5'd0;
  logic        mdio_i = 1'b1;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic [15:0] status;
  logic        irq;

  mdio_status_poller i_mdio_status_poller (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .cfg_irq_en(cfg_irq_en), .cfg_dwell(cfg_dwell), .cfg_rate(cfg_rate), .cfg_phy(cfg_phy),
    .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .status(status), .irq(irq)
  );

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  // ---------------- model PHY ----------------
  logic [15:0] phy_reg = 16'h0000;
  logic [4:0]  exp_phy = 5'd0;
  logic [12:0] hdr;
  int  pos = 0, ones = 0, frames = 0, fmt_err = 0;
  int  rise_cnt = 0, last_end = 0, last_gap = -1;
  bit  want_start = 0, model_clr = 0;

  always @(posedge mdc) begin
    rise_cnt++;
    if (model_clr) begin
      pos = 0; ones = 0; want_start = 0; model_clr = 0;
    end
    if (pos == 0) begin
      if (mdio_oe && want_start) begin
        last_gap = rise_cnt - last_end;
        want_start = 0;
      end
      if (mdio_oe && mdio_o) ones++;
      else if (mdio_oe && !mdio_o && ones >= 32) begin
        if (ones != 32) fmt_err++;
        pos = 1;
        hdr = '0;
      end else ones = 0;
    end else begin
      pos++;
      if (pos <= 14) begin
        hdr = {hdr[11:0], mdio_o};
        if (!mdio_oe) fmt_err++;
      end else if (mdio_oe) fmt_err++;
      if (pos == 32) begin
        if (hdr != {1'b1, 2'b10, exp_phy, 5'd1}) fmt_err++;
        frames++;
        last_end = rise_cnt;
        want_start = 1;
        pos = 0;
        ones = 0;
      end
    end
  end

  always @(negedge mdc) begin
    if (pos >= 16 && pos <= 31) mdio_i = phy_reg[31 - pos];
    else mdio_i = 1'b1;
  end

  // ---------------- irq monitor ----------------
  int irq_cnt = 0, irq_wide = 0;
  bit irq_prev = 0;
  always @(posedge clk) begin
    #1;
    if (irq) irq_cnt++;
    if (irq && irq_prev) irq_wide++;
    irq_prev = irq;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic hard_reset();
    @(posedge clk); #1;
    rst = 1'b1; cfg_we = 3'b000;
    clks(3);
    rst = 1'b0;
    model_clr = 1;
    fmt_err = 0;
    clks(2);
  endtask

  task automatic cfg_write(input logic [2:0] we, input bit en, input bit ie,
                           input logic [2:0] dw, input logic [1:0] rt, input logic [4:0] pa);
    cfg_we = we; cfg_en = en; cfg_irq_en = ie; cfg_dwell = dw; cfg_rate = rt; cfg_phy = pa;
    if (we[2]) exp_phy = pa;
    clks(1);
    cfg_we = 3'b000;
  endtask

  task automatic wait_frames(input int n);
    int s;
    s = frames;
    while (frames < s + n) @(posedge clk);
    clks(4);
  endtask

  task automatic mdc_period(output int p);
    realtime t0;
    repeat (3) @(posedge mdc);
    t0 = $realtime;
    @(posedge mdc);
    p = int'(($realtime - t0) / 20.0);
    #1;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_defaults();
    int p;
    hard_reset();
    chk(status == 16'h0, "R8 status after reset", status, 0);
    chk(irq == 1'b0 && mdio_oe == 1'b0 && mdc == 1'b0, "R8 irq/oe/mdc after reset",
        {irq, mdio_oe, mdc}, 0);
    phy_reg = 16'h3C5A;
    cfg_write(3'b001, 1'b1, 1'b1, 3'b000, 2'b00, 5'd0);
    mdc_period(p);
    chk(p == 8, "R8 default rate code 00", p, 8);
    wait_frames(2);
    chk(last_gap == 1025, "R8 default dwell 100", last_gap, 1025);
    chk(fmt_err == 0, "R2 frame with PHY address 0", fmt_err, 0);
    chk(status == 16'h3C5A, "R2 status read at default rate", status, 16'h3C5A);
  endtask

  task automatic t_disabled_idle();
    int f;
    hard_reset();
    f = frames;
    clks(3000);
    chk(frames == f, "R1 no frames while disabled", frames, f);
    chk(mdio_oe == 1'b0, "R1 oe low while disabled", mdio_oe, 0);
  endtask

  task automatic t_frame_format();
    hard_reset();
    phy_reg = 16'hA5C3;
    cfg_write(3'b111, 1'b1, 1'b1, 3'b000, 2'b01, 5'h15);
    wait_frames(3);
    chk(fmt_err == 0, "R2 frame fields addr 0x15", fmt_err, 0);
    chk(status == 16'hA5C3, "R2 data MSB first", status, 16'hA5C3);
  endtask

  task automatic t_first_and_change();
    int base;
    hard_reset();
    phy_reg = 16'h7849;
    cfg_write(3'b111, 1'b1, 1'b1, 3'b000, 2'b01, 5'd3);
    base = irq_cnt;
    wait_frames(1);
    chk(status == 16'h7849, "R5 priming read loads status", status, 16'h7849);
    chk(irq_cnt == base, "R5 no irq on priming read", irq_cnt, base);
    phy_reg = 16'h0F0F;
    wait_frames(2);
    chk(irq_cnt == base + 1, "R6 one irq on change", irq_cnt, base + 1);
    chk(status == 16'h0F0F, "R6 status updated", status, 16'h0F0F);
    wait_frames(2);
    chk(irq_cnt == base + 1, "R6 no irq on equal reads", irq_cnt, base + 1);
    chk(irq_wide == 0, "R6 irq single cycle", irq_wide, 0);
  endtask

  task automatic t_irq_mask();
    int base;
    hard_reset();
    phy_reg = 16'h1111;
    cfg_write(3'b111, 1'b1, 1'b0, 3'b000, 2'b01, 5'd7);
    base = irq_cnt;
    wait_frames(1);
    phy_reg = 16'h2222;
    wait_frames(2);
    chk(status == 16'h2222, "R7 status tracks with irq off", status, 16'h2222);
    chk(irq_cnt == base, "R7 no irq when masked", irq_cnt, base);
    cfg_write(3'b001, 1'b1, 1'b1, 3'b000, 2'b00, 5'd0);
    phy_reg = 16'h3333;
    wait_frames(2);
    chk(irq_cnt == base + 1, "R7 irq after unmask", irq_cnt, base + 1);
  endtask

  task automatic t_rates();
    int p;
    hard_reset();
    cfg_write(3'b100, 1'b0, 1'b0, 3'b000, 2'b00, 5'd0);
    mdc_period(p); chk(p == 8, "R3 rate 00", p, 8);
    cfg_write(3'b100, 1'b0, 1'b0, 3'b000, 2'b01, 5'd0);
    mdc_period(p); chk(p == 2, "R3 rate 01", p, 2);
    cfg_write(3'b100, 1'b0, 1'b0, 3'b000, 2'b10, 5'd0);
    mdc_period(p); chk(p == 4, "R3 rate 10", p, 4);
    cfg_write(3'b100, 1'b0, 1'b0, 3'b000, 2'b11, 5'd0);
    mdc_period(p); chk(p == 8, "R3 rate 11 reserved", p, 8);
  endtask

  task automatic dwell_case(input logic [2:0] code, input int exp_gap);
    cfg_write(3'b010, 1'b0, 1'b0, code, 2'b00, 5'd0);
    wait_frames(2);
    chk(last_gap == exp_gap, $sformatf("R4 dwell code %0d", code), last_gap, exp_gap);
  endtask

  task automatic t_dwell();
    hard_reset();
    cfg_write(3'b111, 1'b1, 1'b0, 3'b000, 2'b01, 5'd1);
    dwell_case(3'b000, 1);
    dwell_case(3'b001, 129);
    dwell_case(3'b011, 513);
    dwell_case(3'b101, 2049);
    dwell_case(3'b110, 1);
    dwell_case(3'b111, 1);
    dwell_case(3'b010, 257);
  endtask

  task automatic t_disable();
    int f;
    hard_reset();
    cfg_write(3'b111, 1'b1, 1'b1, 3'b000, 2'b01, 5'd2);
    wait_frames(1);
    cfg_write(3'b001, 1'b0, 1'b1, 3'b000, 2'b00, 5'd0);
    clks(300);
    f = frames;
    clks(1500);
    chk(frames == f, "R1 polling stops after disable", frames, f);
    chk(mdio_oe == 1'b0, "R1 oe released after disable", mdio_oe, 0);
  endtask

  task automatic t_soft_reset();
    int base, p;
    hard_reset();
    phy_reg = 16'h4444;
    cfg_write(3'b111, 1'b1, 1'b1, 3'b000, 2'b10, 5'd9);
    wait_frames(1);
    while (pos < 20) @(posedge clk);
    #1;
    phy_reg = 16'h5555;
    base = irq_cnt;
    soft_rst = 1'b1;
    model_clr = 1;
    clks(1);
    soft_rst = 1'b0;
    chk(mdio_oe == 1'b0, "R9 soft reset releases line", mdio_oe, 0);
    chk(status == 16'h4444, "R9 status kept by soft reset", status, 16'h4444);
    wait_frames(1);
    chk(status == 16'h5555, "R9 read after soft reset", status, 16'h5555);
    chk(irq_cnt == base, "R9 priming after soft reset", irq_cnt, base);
    chk(fmt_err == 0, "R9 address kept by soft reset", fmt_err, 0);
    mdc_period(p);
    chk(p == 4, "R9 rate kept by soft reset", p, 4);
  endtask

  // ---------------- main ----------------
  bit finished = 0;

  initial begin
    clks(2);
    t_reset_defaults();
    t_disabled_idle();
    t_frame_format();
    t_first_and_change();
    t_irq_mask();
    t_rates();
    t_dwell();
    t_disable();
    t_soft_reset();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule